// File: doc/BRIEF.md
# Zone Write Permission Gate

This block sits between a command decoder and a byte-wide nonvolatile user array that is split into 16 zones of 128 bytes each. Each zone carries a 2-bit access mode. For every byte of a write command, the gate decides in the same cycle whether the byte may be stored. One cycle later it presents the value that should really be committed, together with its flat array address. The caller supplies the byte currently stored at the target address. In write-lock zones the caller also supplies the lock byte of the target's 8-byte page, which is the byte at the page offset whose three low address bits are zero.

A small command tracker follows the beats of one command. A beat is one byte of a write request.

| State | Meaning |
|---|---|
| `CS_IDLE` | No command is open. |
| `CS_PAGE` | A multi-byte command in a normal, program-only or not-yet-frozen zone is open. Beats are counted up to the page limit. |
| `CS_SINGLE` | A write-lock command is open. Every beat after the first is discarded. |

Transitions:
- **open**: a first beat that is not also the last moves the tracker to `CS_PAGE` or `CS_SINGLE`, chosen by the zone's effective mode.
- **close**: a beat flagged last moves the tracker to `CS_IDLE`.
- **stay**: any other beat leaves the state unchanged.

Top module: `zone_write_gate`

## Requirements
- R1: While reset is applied and right after it, `grant_o`, `commit_valid_o` and `trunc_o` are all 0.
- R2: In a normal zone (mode 0), a beat is granted. One cycle later `commit_valid_o` is 1, `commit_data_o` equals the new data, and `commit_addr_o` equals zone*128 + offset.
- R3: The mode of zone z is taken from `zone_mode_i[2z+1:2z]`, with the encoding 0 normal, 1 write-lock, 2 program-only and 3 modify-forbidden. The lock input is ignored outside mode 1.
- R4: In a program-only zone (mode 2), a beat is granted and the committed value is old AND new, so no stored bit rises from 0 to 1.
- R5: In a modify-forbidden zone (mode 3), every beat is refused while `pers_done_i` is 1. While `pers_done_i` is 0, the zone behaves as a normal zone.
- R6: In a write-lock zone, a byte at page offset k (the offset's low 3 bits) is granted only if bit k of the lock byte is 1. A 0 in bit k means locked. Because of this, a lock byte whose bit 0 is 0 can no longer be written.
- R7: A granted write to a lock byte (offset low 3 bits equal to 0) in a write-lock zone commits old AND new, so lock bits can only be cleared. Other unlocked bytes in the page commit the new data unchanged.
- R8: In a write-lock zone, only the first beat of a command is considered. Every later beat of that command is refused and raises `trunc_o` one cycle later.
- R9: Outside write-lock mode, a command may store up to 16 bytes. Any beat after the 16th is refused and raises `trunc_o` one cycle later.
- R10: A beat that is not flagged first while no command is open is refused, and `trunc_o` stays 0.
- R11: `grant_o` reflects the current beat in the same cycle. `commit_valid_o` pulses in the next cycle exactly for granted beats, and `trunc_o` never coincides with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zone_mode_i | input | 32 | Per-zone 2-bit access mode, zone z at bits 2z+1:2z |
| pers_done_i | input | 1 | Personalization finished; arms modify-forbidden zones |
| req_valid_i | input | 1 | A write beat is present |
| req_first_i | input | 1 | Beat is the first of a command |
| req_last_i | input | 1 | Beat is the last of a command |
| req_zone_i | input | 4 | Target zone |
| req_offset_i | input | 7 | Byte offset inside the zone |
| req_wdata_i | input | 8 | New data |
| req_old_i | input | 8 | Data currently stored at the target |
| req_lock_i | input | 8 | Lock byte of the target's 8-byte page |
| grant_o | output | 1 | Beat accepted (combinational) |
| commit_valid_o | output | 1 | Registered strobe for a value to store |
| commit_addr_o | output | 11 | Flat array address of the committed byte |
| commit_data_o | output | 8 | Value to store |
| trunc_o | output | 1 | A beat was discarded because the command was too long |

## Verification
The bench covers several corner cases; each is listed with the symptom a wrong design would show.
- **Lock byte with every bit set to 1.** A gate that stores the raw data would let lock bits rise again. The correct behaviour keeps them cleared.
- **Lock byte with bit 0 cleared.** A gate that treats the lock byte as always writable would still accept writes to it.
- **Multi-byte command in a write-lock zone.** A gate that honoured the tail bytes would commit them instead of raising the truncation flag.
- **Normal page one beat past 16 bytes.** An off-by-one in the beat counter would either drop the 16th byte or accept the 17th.
- **Stray continuation beat with no open command.** A gate that did not guard this would commit the byte, or would wrongly flag it as truncated.
- **Modify-forbidden zone on both sides of the personalization input.** A gate that ignored the input would either lock too early or never lock.
- **Top zone at offset 127.** A wrong mode-field slice or address concatenation would show here as the wrong mode being applied or the wrong address being reported.

// File: rtl/zwg_pkg.sv
package zwg_pkg;

    typedef enum logic [1:0] {
        ZM_NORMAL = 2'd0,
        ZM_WLOCK  = 2'd1,
        ZM_PROG   = 2'd2,
        ZM_FROZEN = 2'd3
    } zmode_e;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_PAGE   = 2'd1,
        CS_SINGLE = 2'd2
    } cmd_state_e;

endpackage

// File: rtl/zwg_mode_pick.sv
module zwg_mode_pick
    import zwg_pkg::*;
#(
    parameter int ZONES = 16,
    localparam int ZW   = $clog2(ZONES)
) (
    input  logic [2*ZONES-1:0] modes,
    input  logic [ZW-1:0]      zone,
    input  logic               pers_done,
    output zmode_e             eff_mode
);

    zmode_e per_zone [ZONES];

    // Each zone's effective mode; frozen zones act as normal until armed.
    for (genvar z = 0; z < ZONES; z++) begin : g_zone
        zmode_e raw;
        assign raw = zmode_e'(modes[2*z +: 2]);
        assign per_zone[z] = (raw == ZM_FROZEN && !pers_done) ? ZM_NORMAL : raw;
    end

    assign eff_mode = per_zone[zone];

endmodule

// File: rtl/zwg_perm.sv
module zwg_perm
    import zwg_pkg::*;
#(
    parameter int DW        = 8,
    parameter int LOCK_SPAN = 8,
    localparam int SW       = $clog2(LOCK_SPAN)
) (
    input  zmode_e          mode,
    input  logic [SW-1:0]   page_off,
    input  logic [DW-1:0]   lock_byte,
    input  logic [DW-1:0]   new_data,
    input  logic [DW-1:0]   old_data,
    output logic            perm_ok,
    output logic [DW-1:0]   value
);

    logic is_lock_slot;
    assign is_lock_slot = (page_off == '0);

    always_comb begin
        perm_ok = 1'b0;
        value   = old_data;
        unique case (mode)
            ZM_NORMAL: begin
                perm_ok = 1'b1;
                value   = new_data;
            end
            ZM_WLOCK: begin
                // Bit k of the page lock byte guards page offset k; 0 = locked.
                perm_ok = lock_byte[page_off];
                value   = is_lock_slot ? (old_data & new_data) : new_data;
            end
            ZM_PROG: begin
                perm_ok = 1'b1;
                value   = old_data & new_data;
            end
            ZM_FROZEN: begin
                perm_ok = 1'b0;
                value   = old_data;
            end
            default: begin
                perm_ok = 1'b0;
                value   = old_data;
            end
        endcase
    end

endmodule

// File: rtl/zwg_cmd_fsm.sv
module zwg_cmd_fsm
    import zwg_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    localparam int CW        = $clog2(PAGE_BYTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic first,
    input  logic last,
    input  logic single_mode,
    output logic slot_ok,
    output logic trunc_now
);

    cmd_state_e      st, st_nxt;
    logic [CW-1:0]   cnt, cnt_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CS_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        st_nxt    = st;
        cnt_nxt   = cnt;
        slot_ok   = 1'b0;
        trunc_now = 1'b0;
        if (beat) begin
            if (first) begin
                // open: a new command always replaces any open one
                slot_ok = 1'b1;
                cnt_nxt = CW'(1);
                if (last)             st_nxt = CS_IDLE;
                else if (single_mode) st_nxt = CS_SINGLE;
                else                  st_nxt = CS_PAGE;
            end else begin
                unique case (st)
                    CS_IDLE: begin
                        st_nxt = CS_IDLE;
                    end
                    CS_PAGE: begin
                        if (cnt < CW'(PAGE_BYTES)) begin
                            slot_ok = 1'b1;
                            cnt_nxt = cnt + CW'(1);
                        end else begin
                            trunc_now = 1'b1;
                        end
                        if (last) st_nxt = CS_IDLE;
                    end
                    CS_SINGLE: begin
                        trunc_now = 1'b1;
                        if (last) st_nxt = CS_IDLE;
                    end
                    default: begin
                        st_nxt = CS_IDLE;
                    end
                endcase
            end
        end
    end

    // R9: the beat counter never runs past the page limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(PAGE_BYTES));

    // R10: nothing is granted from idle unless it opens a command
    p_idle_orphan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_IDLE && beat && !first) |-> (!slot_ok && !trunc_now));

endmodule

// File: rtl/zone_write_gate.sv
module zone_write_gate
    import zwg_pkg::*;
#(
    parameter int ZONES      = 16,
    parameter int ZONE_BYTES = 128,
    parameter int PAGE_BYTES = 16,
    parameter int DW         = 8,
    localparam int LOCK_SPAN = DW,
    localparam int ZW        = $clog2(ZONES),
    localparam int OW        = $clog2(ZONE_BYTES),
    localparam int AW        = ZW + OW,
    localparam int SW        = $clog2(LOCK_SPAN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*ZONES-1:0] zone_mode_i,
    input  logic               pers_done_i,
    input  logic               req_valid_i,
    input  logic               req_first_i,
    input  logic               req_last_i,
    input  logic [ZW-1:0]      req_zone_i,
    input  logic [OW-1:0]      req_offset_i,
    input  logic [DW-1:0]      req_wdata_i,
    input  logic [DW-1:0]      req_old_i,
    input  logic [DW-1:0]      req_lock_i,
    output logic               grant_o,
    output logic               commit_valid_o,
    output logic [AW-1:0]      commit_addr_o,
    output logic [DW-1:0]      commit_data_o,
    output logic               trunc_o
);

    zmode_e          eff_mode;
    logic            slot_ok;
    logic            trunc_now;
    logic            perm_ok;
    logic [DW-1:0]   merged;
    logic [SW-1:0]   page_off;

    assign page_off = req_offset_i[SW-1:0];

    zwg_mode_pick #(.ZONES(ZONES)) u_mode (
        .modes     (zone_mode_i),
        .zone      (req_zone_i),
        .pers_done (pers_done_i),
        .eff_mode  (eff_mode)
    );

    zwg_cmd_fsm #(.PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (req_valid_i),
        .first       (req_first_i),
        .last        (req_last_i),
        .single_mode (eff_mode == ZM_WLOCK),
        .slot_ok     (slot_ok),
        .trunc_now   (trunc_now)
    );

    zwg_perm #(.DW(DW), .LOCK_SPAN(LOCK_SPAN)) u_perm (
        .mode      (eff_mode),
        .page_off  (page_off),
        .lock_byte (req_lock_i),
        .new_data  (req_wdata_i),
        .old_data  (req_old_i),
        .perm_ok   (perm_ok),
        .value     (merged)
    );

    assign grant_o = req_valid_i && slot_ok && perm_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid_o <= 1'b0;
            commit_addr_o  <= '0;
            commit_data_o  <= '0;
            trunc_o        <= 1'b0;
        end else begin
            commit_valid_o <= grant_o;
            trunc_o        <= req_valid_i && trunc_now;
            if (grant_o) begin
                commit_addr_o <= {req_zone_i, req_offset_i};
                commit_data_o <= merged;
            end
        end
    end

    // R11: a commit strobe only follows a granted beat
    p_commit_after_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid_o |-> $past(grant_o));

    // R8: a discarded beat never also produces a commit
    p_trunc_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_o |-> !commit_valid_o);

    // R6: a locked page slot is never granted
    p_locked_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && eff_mode == ZM_WLOCK && !req_lock_i[page_off]) |-> !grant_o);

    // R5: an armed modify-forbidden zone refuses every beat
    p_frozen_zone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && pers_done_i && zone_mode_i[2*req_zone_i +: 2] == 2'd3) |-> !grant_o);

    // R4: program-only commits never raise a stored bit
    p_prog_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_o && $past(eff_mode == ZM_PROG)) |->
            ((commit_data_o & ~$past(req_old_i)) == '0));

endmodule

// File: tb/zone_write_gate_test.sv
module zone_write_gate_test;

    typedef struct {
        bit          v;
        bit          t;
        logic [7:0]  d;
        logic [10:0] a;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] zone_mode = 32'h8000_00E4;
    logic        pers_done = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_first = 1'b0;
    logic        req_last = 1'b0;
    logic [3:0]  req_zone = '0;
    logic [6:0]  req_offset = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  req_old = '0;
    logic [7:0]  req_lock = '0;
    logic        grant;
    logic        commit_valid;
    logic [10:0] commit_addr;
    logic [7:0]  commit_data;
    logic        trunc;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    zone_write_gate uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .zone_mode_i    (zone_mode),
        .pers_done_i    (pers_done),
        .req_valid_i    (req_valid),
        .req_first_i    (req_first),
        .req_last_i     (req_last),
        .req_zone_i     (req_zone),
        .req_offset_i   (req_offset),
        .req_wdata_i    (req_wdata),
        .req_old_i      (req_old),
        .req_lock_i     (req_lock),
        .grant_o        (grant),
        .commit_valid_o (commit_valid),
        .commit_addr_o  (commit_addr),
        .commit_data_o  (commit_data),
        .trunc_o        (trunc)
    );

    task automatic beat(input bit first, input bit last, input logic [3:0] z,
                        input logic [6:0] off, input logic [7:0] nd, input logic [7:0] od,
                        input logic [7:0] lk, input bit eg, input logic [7:0] ed,
                        input bit et, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_first = first; req_last = last;
        req_zone = z; req_offset = off; req_wdata = nd; req_old = od; req_lock = lk;
        #1;
        checks++;
        if (grant !== eg) begin
            errors++;
            $display("FAIL %s grant got %0b exp %0b", tag, grant, eg);
        end
        e.v = eg; e.t = et; e.d = ed; e.a = {z, off}; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_first = 1'b0; req_last = 1'b0;
    endtask

    // Monitor: compare registered results against the scoreboard queue
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (mon_on) begin
            checks++;
            if (q.size() > 0) begin
                e = q.pop_front();
                if (commit_valid !== e.v || trunc !== e.t ||
                    (e.v && (commit_data !== e.d || commit_addr !== e.a))) begin
                    errors++;
                    $display("FAIL %s commit v/t/d/a got %0b/%0b/%h/%h exp %0b/%0b/%h/%h",
                             e.tag, commit_valid, trunc, commit_data, commit_addr,
                             e.v, e.t, e.d, e.a);
                end
            end else if (commit_valid !== 1'b0 || trunc !== 1'b0) begin
                errors++;
                $display("FAIL R11 idle cycle commit/trunc got %0b/%0b exp 0/0",
                         commit_valid, trunc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (grant !== 1'b0 || commit_valid !== 1'b0 || trunc !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset got %0b%0b%0b exp 000", grant, commit_valid, trunc);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (grant !== 1'b0 || commit_valid !== 1'b0 || trunc !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset got %0b%0b%0b exp 000", grant, commit_valid, trunc);
        end
        mon_on = 1'b1;

        // R2: normal zone, lock input ignored (R3)
        beat(1, 1, 4'd0, 7'd5, 8'hA5, 8'h3C, 8'h00, 1, 8'hA5, 0, "R2 normal single");
        // R4: program-only
        beat(1, 1, 4'd2, 7'h10, 8'hF0, 8'h3C, 8'h00, 1, 8'h30, 0, "R4 program-only and");
        // R3: top zone mode field and top address
        beat(1, 1, 4'd15, 7'd127, 8'h0F, 8'hF5, 8'h00, 1, 8'h05, 0, "R3 zone15 offset127");
        // R5: frozen zone before and after personalization
        beat(1, 1, 4'd3, 7'd1, 8'h55, 8'hAA, 8'h00, 1, 8'h55, 0, "R5 unarmed behaves normal");
        idle();
        pers_done = 1'b1;
        beat(1, 1, 4'd3, 7'd1, 8'h55, 8'hAA, 8'h00, 0, 8'h00, 0, "R5 armed refuses");
        // R6: locked and unlocked page slots
        beat(1, 1, 4'd1, 7'd11, 8'hC3, 8'h00, 8'hF7, 0, 8'h00, 0, "R6 bit3 locked");
        beat(1, 1, 4'd1, 7'd11, 8'hC3, 8'h00, 8'h09, 1, 8'hC3, 0, "R6 bit3 open");
        // R7: lock byte bits only clear
        beat(1, 1, 4'd1, 7'd16, 8'hFF, 8'hD9, 8'hD9, 1, 8'hD9, 0, "R7 lock no set");
        beat(1, 1, 4'd1, 7'd16, 8'h18, 8'hD9, 8'hD9, 1, 8'h18, 0, "R7 lock clear");
        beat(1, 1, 4'd1, 7'd16, 8'h00, 8'hD8, 8'hD8, 0, 8'h00, 0, "R6 lock byte self-locked");
        // R8: write-lock multi-byte command drops the tail
        beat(1, 0, 4'd1, 7'd9, 8'h11, 8'h00, 8'hFF, 1, 8'h11, 0, "R8 first kept");
        beat(0, 0, 4'd1, 7'd10, 8'h22, 8'h00, 8'hFF, 0, 8'h00, 1, "R8 second dropped");
        beat(0, 1, 4'd1, 7'd11, 8'h33, 8'h00, 8'hFF, 0, 8'h00, 1, "R8 third dropped");
        idle();
        // R10: stray continuation beat
        beat(0, 1, 4'd0, 7'd40, 8'h77, 8'h00, 8'h00, 0, 8'h00, 0, "R10 orphan beat");
        idle();
        // R9: normal page of 17 beats
        for (int i = 0; i < 17; i++) begin
            beat(i == 0, i == 16, 4'd0, 7'(32 + i), 8'(i + 1), 8'hFF, 8'h00,
                 i < 16, 8'(i + 1), i == 16, "R9 page length");
        end
        idle();
        // R4 with R11: program-only two-beat command, back to back
        beat(1, 0, 4'd2, 7'h20, 8'h0F, 8'hFF, 8'h00, 1, 8'h0F, 0, "R11 prog beat0");
        beat(0, 1, 4'd2, 7'h21, 8'hFF, 8'h81, 8'h00, 1, 8'h81, 0, "R4 prog beat1");
        idle();
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule